// File: doc/BRIEF.md
# Masked vector element sequencer

This block walks the elements of one vector register group, one element per clock, and writes the result of a small element operation into a destination register buffer. Each run has a start index, a vector length, a packed descriptor and an element size. Elements below the start index are never touched. Elements from the start index up to the vector length form the body. In the body, a per-element mask bit decides whether the operation result is written, whether the element is overwritten with all ones, or whether it is left as it was. After the body, the tail runs up to the group's total element count. When the tail-agnostic policy is selected, the tail is filled with all ones.

The total element count comes from a signed group-multiplier code, the selected element width (SEW) and the element size. Fractional multipliers clamp the group to one whole register, so the tail fill reaches the end of that register. Source operands come in through a narrow request port: the block presents an element index and reads two 64-bit operands in the same cycle. When idle, a host word port preloads the buffer and reads it back. The block starts on a pulse, reports busy and gives a one-cycle done pulse. It flags illegal configurations and performs no writes for them.

Top module: `vec_elem_seq`

## Requirements
- R1: After a legal start, the operation applies to element indices vstart through vl-1 only. Elements below vstart keep their previous contents.
- R2: The operation is selected by op_i: 0 passes the vs2 operand (op_a_i), 1 computes op_a_i + op_b_i, 2 computes op_a_i - op_b_i, and 3 behaves as 0. The result is truncated to the element size.
- R3: The mask bit for element i is mask_i[i], which is bit i mod 64 of 64-bit mask word i/64 (word w is mask_i[64w+63:64w]). With desc_i[3]=0, an element whose mask bit is 0 is not computed. It is filled with all ones if desc_i[5]=1 and left unchanged otherwise. With desc_i[3]=1, every body element is computed.
- R4: If desc_i[4]=1, elements vl through total-1 are filled with all ones. If desc_i[4]=0, they are unchanged. Elements at or beyond total are never written.
- R5: desc_i[2:0] is a signed multiplier exponent: 000=0, 001=1, 010=2, 011=3, 101=-3, 110=-2, 111=-1. The group exponent is esz_i - sew_i + that value, clamped below at 0. total = (VLENB << exponent) / element bytes, limited to the buffer capacity of VLENB*8 bytes.
- R6: esz_i selects element sizes of 1, 2, 4 or 8 bytes (codes 0 to 3). Element i occupies buffer bytes i*size through i*size+size-1. Buffer byte b sits in word b/8 at bits 8*(b mod 8)+7 down to 8*(b mod 8). Writes and fills cover the element's full width.
- R7: A start is illegal when desc_i[2:0]=100, when vstart >= vl, or when vl exceeds the buffer capacity in elements. An illegal start writes nothing, raises illegal_o together with done_o, and clears the start index register.
- R8: A start pulse while idle makes busy_o high from the next cycle. vstart_o holds the start index during the run. done_o is a one-cycle pulse with busy_o low, and vstart_o reads 0 from then on.
- R9: During the body, elem_req_o is high for exactly vl-vstart cycles. elem_idx_o rises by one each cycle from vstart, and the operands are taken in the same cycle.
- R10: Host writes (host_we_i) update a whole buffer word only while the block is idle and are ignored while busy. host_rdata_o returns the word at host_raddr_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| vstart_i | input | IDX_W | First element index |
| vl_i | input | IDX_W | Vector length (end of body, exclusive) |
| desc_i | input | 6 | [2:0] multiplier code, [3] mask disable, [4] tail agnostic, [5] mask agnostic |
| sew_i | input | 2 | log2 of SEW in bytes |
| esz_i | input | 2 | log2 of element size in bytes |
| op_i | input | 2 | Element operation select |
| mask_i | input | MASK_W | Per-element mask bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Last start was illegal |
| vstart_o | output | IDX_W | Start index register |
| elem_req_o | output | 1 | Operand request for elem_idx_o |
| elem_idx_o | output | IDX_W | Current element index |
| op_a_i | input | 64 | vs2 operand for elem_idx_o |
| op_b_i | input | 64 | vs1 or scalar operand for elem_idx_o |
| host_we_i | input | 1 | Host word write enable |
| host_addr_i | input | AW | Host write word address |
| host_wdata_i | input | 64 | Host write data |
| host_raddr_i | input | AW | Host read word address |
| host_rdata_o | output | 64 | Host read data (one-cycle latency) |

## Verification
The bench sweeps every combination of element size, SEW and multiplier code, including the reserved code. It varies the start index, the vector length, the policy bits, the operation and a rotating mask pattern. A byte-level model of the whole buffer is compared word by word after each run. Because the buffer is preloaded with a pattern that is distinct per byte and per run, one comparison separates an untouched prestart byte, a computed result, an all-ones fill and a preserved old value. The sweep over fractional and large multipliers separates a correct clamp from an unclamped or wrongly signed exponent, because the tail end moves with each. Directed runs cover vstart equal to and beyond vl, a vector length over capacity, all-masked and mask-disabled bodies, and a host write issued while busy.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_ALT  = 2'd3
  } elem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK,
    ST_BODY,
    ST_TAIL,
    ST_FIN
  } seq_state_e;

  // descriptor field positions
  localparam int DESC_W        = 6;
  localparam int DESC_LMUL_LSB = 0;
  localparam int DESC_VM_DIS   = 3;
  localparam int DESC_TAIL_AGN = 4;
  localparam int DESC_MASK_AGN = 5;

  localparam logic [2:0] LMUL_RSVD = 3'b100;

  // signed group-multiplier exponent from its 3-bit code
  function automatic int lmul_value(logic [2:0] code);
    return int'($signed(code));
  endfunction

endpackage

// File: rtl/vseq_cfg_decode.sv
module vseq_cfg_decode
  import vseq_pkg::*;
#(
  parameter int VLENB = 16,
  parameter int IDX_W = 8
) (
  input  logic [2:0]       lmul_code,
  input  logic [1:0]       sew_log,
  input  logic [1:0]       esz_log,
  input  logic [IDX_W-1:0] vstart,
  input  logic [IDX_W-1:0] vl,
  output logic [IDX_W-1:0] total,
  output logic             illegal
);
  localparam int BUF_BYTES = VLENB * 8;

  int grp_exp;
  int tot;
  int cap;

  always_comb begin
    grp_exp = int'(esz_log) - int'(sew_log) + lmul_value(lmul_code);
    if (grp_exp < 0) grp_exp = 0;
    tot = (VLENB << grp_exp) >> esz_log;
    cap = BUF_BYTES >> esz_log;
    if (tot > cap) tot = cap;
    total   = IDX_W'(tot);
    illegal = (lmul_code == LMUL_RSVD) || (vstart >= vl) || (int'(vl) > cap);
  end

endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
  import vseq_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int AW    = 4
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       esz_log,
  input  elem_op_e         op,
  input  logic [63:0]      opnd_a,
  input  logic [63:0]      opnd_b,
  input  logic             sel_ones,
  output logic [AW-1:0]    word,
  output logic [7:0]       be,
  output logic [63:0]      wdata
);
  localparam int BOFF_W = AW + 3;

  logic [BOFF_W-1:0] boff;
  logic [2:0]        base;
  logic [7:0]        emask;
  logic [63:0]       res;
  logic [63:0]       val;

  always_comb begin
    boff = BOFF_W'(idx) << esz_log;
    word = boff[BOFF_W-1:3];
    base = boff[2:0];
    case (esz_log)
      2'd0:    emask = 8'h01;
      2'd1:    emask = 8'h03;
      2'd2:    emask = 8'h0F;
      default: emask = 8'hFF;
    endcase
    be = emask << base;
    case (op)
      OP_ADD:  res = opnd_a + opnd_b;
      OP_SUB:  res = opnd_a - opnd_b;
      default: res = opnd_a;
    endcase
    val   = sel_ones ? '1 : res;
    wdata = val << {base, 3'b000};
  end

endmodule

// File: rtl/vseq_dbuf.sv
module vseq_dbuf #(
  parameter int NW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    be,
  input  logic [63:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [63:0]   rdata
);
  for (genvar g = 0; g < 8; g++) begin : g_lane
    logic [7:0] mem [NW];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (we && be[g]) mem[waddr] <= wdata[8*g +: 8];
      rd_q <= mem[raddr];
    end

    assign rdata[8*g +: 8] = rd_q;
  end

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter  int VLENB     = 16,
  localparam int BUF_BYTES = VLENB * 8,
  localparam int IDX_W     = $clog2(BUF_BYTES) + 1,
  localparam int AW        = $clog2(BUF_BYTES / 8),
  localparam int MASK_W    = BUF_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  vstart_i,
  input  logic [IDX_W-1:0]  vl_i,
  input  logic [5:0]        desc_i,
  input  logic [1:0]        sew_i,
  input  logic [1:0]        esz_i,
  input  logic [1:0]        op_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic [IDX_W-1:0]  vstart_o,
  output logic              elem_req_o,
  output logic [IDX_W-1:0]  elem_idx_o,
  input  logic [63:0]       op_a_i,
  input  logic [63:0]       op_b_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [63:0]       host_wdata_i,
  input  logic [AW-1:0]     host_raddr_i,
  output logic [63:0]       host_rdata_o
);
  localparam int NW     = BUF_BYTES / 8;
  localparam int MIDX_W = $clog2(MASK_W);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  vstart_q;
  logic [IDX_W-1:0]  vl_q;
  logic [2:0]        lmul_q;
  logic [1:0]        sew_q;
  logic [1:0]        esz_q;
  elem_op_e          op_q;
  logic              vmdis_q;
  logic              tagn_q;
  logic              magn_q;
  logic [MASK_W-1:0] mask_q;
  logic              busy_q;
  logic              done_q;
  logic              ill_q;

  logic [IDX_W-1:0]  total;
  logic              cfg_bad;
  logic              active;
  logic              seq_we;
  logic [AW-1:0]     lane_word;
  logic [7:0]        lane_be;
  logic [63:0]       lane_wd;

  logic              buf_we;
  logic [AW-1:0]     buf_addr;
  logic [7:0]        buf_be;
  logic [63:0]       buf_wd;

  vseq_cfg_decode #(
    .VLENB (VLENB),
    .IDX_W (IDX_W)
  ) u_decode (
    .lmul_code (lmul_q),
    .sew_log   (sew_q),
    .esz_log   (esz_q),
    .vstart    (vstart_q),
    .vl        (vl_q),
    .total     (total),
    .illegal   (cfg_bad)
  );

  assign active = vmdis_q | mask_q[idx[MIDX_W-1:0]];
  assign seq_we = ((state == ST_BODY) && (active || magn_q)) || (state == ST_TAIL);

  vseq_lane #(
    .IDX_W (IDX_W),
    .AW    (AW)
  ) u_lane (
    .idx      (idx),
    .esz_log  (esz_q),
    .op       (op_q),
    .opnd_a   (op_a_i),
    .opnd_b   (op_b_i),
    .sel_ones ((state != ST_BODY) || !active),
    .word     (lane_word),
    .be       (lane_be),
    .wdata    (lane_wd)
  );

  // host port owns the buffer only while idle
  always_comb begin
    if (busy_q) begin
      buf_we   = seq_we;
      buf_addr = lane_word;
      buf_be   = lane_be;
      buf_wd   = lane_wd;
    end else begin
      buf_we   = host_we_i;
      buf_addr = host_addr_i;
      buf_be   = 8'hFF;
      buf_wd   = host_wdata_i;
    end
  end

  vseq_dbuf #(
    .NW (NW),
    .AW (AW)
  ) u_dbuf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .be    (buf_be),
    .wdata (buf_wd),
    .raddr (host_raddr_i),
    .rdata (host_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      vstart_q <= '0;
      vl_q     <= '0;
      lmul_q   <= '0;
      sew_q    <= '0;
      esz_q    <= '0;
      op_q     <= OP_PASS;
      vmdis_q  <= 1'b0;
      tagn_q   <= 1'b0;
      magn_q   <= 1'b0;
      mask_q   <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            vstart_q <= vstart_i;
            vl_q     <= vl_i;
            lmul_q   <= desc_i[DESC_LMUL_LSB +: 3];
            vmdis_q  <= desc_i[DESC_VM_DIS];
            tagn_q   <= desc_i[DESC_TAIL_AGN];
            magn_q   <= desc_i[DESC_MASK_AGN];
            sew_q    <= sew_i;
            esz_q    <= esz_i;
            op_q     <= elem_op_e'(op_i);
            mask_q   <= mask_i;
            busy_q   <= 1'b1;
            ill_q    <= 1'b0;
            state    <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (cfg_bad) begin
            ill_q <= 1'b1;
            state <= ST_FIN;
          end else begin
            idx   <= vstart_q;
            state <= ST_BODY;
          end
        end
        ST_BODY: begin
          idx <= idx + 1'b1;
          if (idx == vl_q - 1'b1) begin
            if (tagn_q && (vl_q < total)) state <= ST_TAIL;
            else                          state <= ST_FIN;
          end
        end
        ST_TAIL: begin
          idx <= idx + 1'b1;
          if (idx == total - 1'b1) state <= ST_FIN;
        end
        default: begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          vstart_q <= '0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign illegal_o  = ill_q;
  assign vstart_o   = vstart_q;
  assign elem_req_o = (state == ST_BODY);
  assign elem_idx_o = idx;

endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             illegal_o,
  input logic [IDX_W-1:0] vstart_o,
  input logic             elem_req_o,
  input logic [IDX_W-1:0] elem_idx_o
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R8
  vstart_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (vstart_o == '0));

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  // R9
  req_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    elem_req_o |-> busy_o);

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (elem_req_o && $past(elem_req_o)) |-> (elem_idx_o == $past(elem_idx_o) + 1'b1));

  // R7
  illegal_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !elem_req_o);

endmodule

bind vec_elem_seq vseq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .illegal_o  (illegal_o),
  .vstart_o   (vstart_o),
  .elem_req_o (elem_req_o),
  .elem_idx_o (elem_idx_o)
);

// File: tb/vec_elem_seq_tb.sv
module vec_elem_seq_tb;
  localparam int VLENB = 16;
  localparam int BUF   = VLENB * 8;
  localparam int IDX_W = $clog2(BUF) + 1;
  localparam int AW    = $clog2(BUF / 8);
  localparam int NW    = BUF / 8;
  localparam int MW    = BUF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst;
  logic             start;
  logic [IDX_W-1:0] vstart, vl;
  logic [5:0]       desc;
  logic [1:0]       sew, esz, op;
  logic [MW-1:0]    mask;
  logic             busy, done, ill, ereq;
  logic [IDX_W-1:0] vs_o, eidx;
  logic [63:0]      opa, opb;
  logic             hwe;
  logic [AW-1:0]    hwa, hra;
  logic [63:0]      hwd, hrd;

  int total_n = 0;
  int bad_n   = 0;
  int reqs;
  logic [7:0] model [BUF];

  function automatic logic [63:0] fa(logic [IDX_W-1:0] i);
    return 64'h0123_4567_89AB_CDEF ^ ({{(64-IDX_W){1'b0}}, i} * 64'h0001_0203_0405_0607);
  endfunction

  function automatic logic [63:0] fb(logic [IDX_W-1:0] i);
    return {{(64-IDX_W){1'b0}}, i} * 64'h0101_0101_0101_0101 + 64'h11;
  endfunction

  assign opa = fa(eidx);
  assign opb = fb(eidx);

  vec_elem_seq #(.VLENB(VLENB)) u_dut (
    .clk (clk), .rst (rst), .start_i (start), .vstart_i (vstart), .vl_i (vl),
    .desc_i (desc), .sew_i (sew), .esz_i (esz), .op_i (op), .mask_i (mask),
    .busy_o (busy), .done_o (done), .illegal_o (ill), .vstart_o (vs_o),
    .elem_req_o (ereq), .elem_idx_o (eidx), .op_a_i (opa), .op_b_i (opb),
    .host_we_i (hwe), .host_addr_i (hwa), .host_wdata_i (hwd),
    .host_raddr_i (hra), .host_rdata_o (hrd)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (ereq) reqs++;
  endtask

  // R5: total element count from the requirement formula
  function automatic int exp_total(int ec, int sc, int lc);
    int lm, e, t;
    lm = (lc >= 4) ? lc - 8 : lc;
    if (lc == 4) lm = 0;
    e = ec - sc + lm;
    if (e < 0) e = 0;
    t = (VLENB << e) >> ec;
    if (t > (BUF >> ec)) t = BUF >> ec;
    return t;
  endfunction

  task automatic put_elem(int i, int ec, logic [63:0] v);
    int nb;
    nb = 1 << ec;
    for (int k = 0; k < nb; k++) model[i*nb + k] = v[8*k +: 8];
  endtask

  task automatic run(input int vs, input int vlen, input int ec, input int sc,
                     input int lc, input int oc, input bit vmd, input bit vta,
                     input bit vma, input logic [MW-1:0] m, input int seed,
                     input bit poke);
    bit exp_ill;
    int tot;
    logic [63:0] w, r;
    // preload buffer and model
    for (int wi = 0; wi < NW; wi++) begin
      for (int k = 0; k < 8; k++) begin
        w[8*k +: 8] = 8'((wi*8 + k) * 29 + seed * 7 + 3);
        model[wi*8 + k] = w[8*k +: 8];
      end
      @(negedge clk);
      hwe = 1'b1; hwa = AW'(wi); hwd = w;
    end
    @(negedge clk);
    hwe = 1'b0;
    // expected contents
    tot = exp_total(ec, sc, lc);
    exp_ill = (lc == 4) || (vs >= vlen) || (vlen > (BUF >> ec));
    if (!exp_ill) begin
      for (int i = vs; i < vlen; i++) begin
        if (vmd || m[i]) begin
          r = fa(IDX_W'(i));
          if (oc == 1) r = fa(IDX_W'(i)) + fb(IDX_W'(i));
          if (oc == 2) r = fa(IDX_W'(i)) - fb(IDX_W'(i));
          put_elem(i, ec, r);
        end else if (vma) begin
          put_elem(i, ec, '1);
        end
      end
      if (vta) for (int i = vlen; i < tot; i++) put_elem(i, ec, '1);
    end
    // launch
    vstart = IDX_W'(vs); vl = IDX_W'(vlen);
    desc = {vma, vta, vmd, 3'(lc)};
    sew = 2'(sc); esz = 2'(ec); op = 2'(oc); mask = m;
    start = 1'b1;
    reqs = 0;
    tick();
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 64'd1);
    chk(vs_o == IDX_W'(vs), "R8", "start index held", 64'(vs_o), 64'(vs));
    if (poke) begin
      // R10: write while busy must be ignored
      hwe = 1'b1; hwa = '0; hwd = 64'h0;
      tick();
      hwe = 1'b0;
    end
    while (done !== 1'b1) tick();
    chk(ill == exp_ill, "R7", "illegal flag", 64'(ill), 64'(exp_ill));
    chk(vs_o == '0, "R8", "start index cleared", 64'(vs_o), 64'd0);
    chk(busy == 1'b0, "R8", "idle at done", 64'(busy), 64'd0);
    chk(reqs == (exp_ill ? 0 : vlen - vs), "R9", "request cycles",
        64'(reqs), 64'(exp_ill ? 0 : vlen - vs));
    tick();
    chk(done == 1'b0, "R8", "done single cycle", 64'(done), 64'd0);
    // readback
    for (int wi = 0; wi < NW; wi++) begin
      hra = AW'(wi);
      @(negedge clk);
      for (int k = 0; k < 8; k++) w[8*k +: 8] = model[wi*8 + k];
      chk(hrd == w, "R1 R2 R3 R4 R5 R6 R10", $sformatf("word %0d", wi), hrd, w);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad_n++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    logic [MW-1:0] mbase, mrot;
    int k, t, vs, vlen, sh;
    rst = 1'b1; start = 1'b0; vstart = '0; vl = '0; desc = '0;
    sew = '0; esz = '0; op = '0; mask = '0;
    hwe = 1'b0; hwa = '0; hwd = '0; hra = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0, "R8", "reset busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R8", "reset done", 64'(done), 64'd0);
    chk(ill == 1'b0, "R7", "reset illegal", 64'(ill), 64'd0);
    chk(vs_o == '0, "R8", "reset start index", 64'(vs_o), 64'd0);
    chk(ereq == 1'b0, "R9", "reset request", 64'(ereq), 64'd0);

    mbase = {64'hF0E1_D2C3_B4A5_9687, 64'h1357_9BDF_2468_ACE0};
    k = 0;
    // sweep: element size x SEW x multiplier code (R5, R6, R2, R3, R4)
    for (int ec = 0; ec < 4; ec++)
      for (int sc = 0; sc < 4; sc++)
        for (int lc = 0; lc < 8; lc++) begin
          t = exp_total(ec, sc, lc);
          vs = k % 3;
          vlen = t - (k % 4);
          if (vlen <= vs) vlen = vs + 1;
          if (vlen > (BUF >> ec)) vlen = BUF >> ec;
          sh = k % 64;
          mrot = (sh == 0) ? mbase : ((mbase << sh) | (mbase >> (MW - sh)));
          run(vs, vlen, ec, sc, lc, k % 3, (k % 5) == 0, (k % 2) == 1,
              ((k / 2) % 2) == 1, mrot, k, 1'b0);
          k++;
        end
    // R7: start equal to length, start beyond length, length over capacity
    run(5, 5, 0, 0, 0, 1, 1'b1, 1'b1, 1'b1, '1, 200, 1'b0);
    run(9, 4, 1, 1, 1, 1, 1'b1, 1'b1, 1'b1, '1, 201, 1'b0);
    run(0, 17, 3, 3, 3, 0, 1'b1, 1'b1, 1'b1, '1, 202, 1'b0);
    // R10 + R1: host write during run on a prestart word
    run(10, 30, 0, 0, 1, 2, 1'b0, 1'b1, 1'b0, mbase, 203, 1'b1);
    // R3: all masked, undisturbed vs agnostic; mask disabled with zero mask
    run(0, 12, 1, 1, 0, 1, 1'b0, 1'b0, 1'b0, '0, 204, 1'b0);
    run(0, 12, 1, 1, 0, 1, 1'b0, 1'b0, 1'b1, '0, 205, 1'b0);
    run(0, 12, 1, 1, 0, 2, 1'b1, 1'b0, 1'b0, '0, 206, 1'b0);
    // R4: vector length equal to total, no tail; single element with fractional group
    run(0, 16, 0, 0, 0, 1, 1'b1, 1'b1, 1'b0, '1, 207, 1'b0);
    run(0, 1, 2, 0, 7, 0, 1'b1, 1'b1, 1'b0, '1, 208, 1'b0);

    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

endmodule